// File: doc/BRIEF.md
# NMI Error Gating Logic

This block merges three hardware error sources into one non-maskable interrupt request: a PCI parity error, a PCI system error and an ISA I/O channel check. All three error inputs are active low and asynchronous, so each one passes through a two-flop synchronizer. The synchronized error then sets a sticky status flag. A flag can be set only while its port B enable is 1, and it is cleared by writing that enable bit to 0.

The request is built from the flags. A parity error is routed only when two enables are both set: the parity-enable bit of the PCI command register and the "parity signals system error" bit of a function control register. That parity term is ORed with the system-error term, which has its own command-register enable, and the result is gated by the shared port B PCI-error enable. The I/O channel check term, gated by its own port B enable, is ORed in. A global mask bit, bit 7 of port 070h, blocks the whole result. The interrupt output is registered.

Top module: `nmi_err_gate`

## Requirements
- R1: Each error input is synchronized by two flops. An input driven low between clock edges shows up in its status flag after the third rising edge and not after the second.
- R2: Status bit 0 (parity) sets while `perr_n` is low and `pb_pci_err_en` is 1. It stays set after `perr_n` returns high.
- R3: Status bit 1 (system error) sets while `serr_n` is low and `pb_pci_err_en` is 1. It is sticky in the same way, whatever the value of `cmd_serr_en`.
- R4: Status bit 2 (channel check) sets while `iochk_n` is low and `pb_chk_en` is 1. It is sticky.
- R5: While `pb_pci_err_en` is 0, status bits 0 and 1 are cleared on the next edge and errors on their inputs are ignored. `pb_chk_en` does the same for status bit 2.
- R6: A parity flag drives `nmi_o` only when `cmd_perr_en` and `fc_perr_to_serr` are both 1.
- R7: A system error flag drives `nmi_o` only when `cmd_serr_en` is 1.
- R8: While `nmi_mask` is 1, `nmi_o` is 0 one edge later and the status flags are kept. Clearing the mask brings the request back one edge later.
- R9: `nmi_o` is registered. It rises one edge after an enabled, unmasked flag is set and stays high as long as that condition holds.
- R10: After a synchronous reset, `nmi_o` is 0 and all status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| perr_n | input | 1 | PCI parity error, active low, asynchronous |
| serr_n | input | 1 | PCI system error, active low, asynchronous |
| iochk_n | input | 1 | ISA I/O channel check, active low, asynchronous |
| cmd_perr_en | input | 1 | PCI command parity-error enable |
| cmd_serr_en | input | 1 | PCI command system-error enable |
| fc_perr_to_serr | input | 1 | Function control: parity errors signal system error |
| pb_pci_err_en | input | 1 | Port B PCI error enable; 0 clears status bits 0 and 1 |
| pb_chk_en | input | 1 | Port B channel check enable; 0 clears status bit 2 |
| nmi_mask | input | 1 | Port 070h bit 7; 1 masks the interrupt |
| nmi_o | output | 1 | Registered NMI request |
| err_flags_o | output | 3 | Sticky status: bit 0 parity, bit 1 system, bit 2 channel check |

## Verification
The hardest case to reach is a status flag that has been latched while its routing is closed: for example, a system error recorded while `cmd_serr_en` is 0, or a parity flag held while the mask is set. That flag must stay silent and then raise the request exactly one edge after the gate opens. Directed sequences build this state on purpose and then switch each gate on its own. After that, a long random phase with rare error pulses and mostly-set enables covers the mixed cases, comparing every cycle against a reference model in the bench.

// File: rtl/nmi_gate_pkg.sv
package nmi_gate_pkg;
  localparam int NUM_SRC   = 3;
  localparam int SRC_PERR  = 0;
  localparam int SRC_SERR  = 1;
  localparam int SRC_IOCHK = 2;

  typedef struct packed {
    logic perr_en;
    logic serr_en;
    logic perr_to_serr;
    logic pci_err_en;
    logic chk_en;
    logic mask;
  } nmi_cfg_t;
endpackage

// File: rtl/nmi_in_sync.sv
module nmi_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/nmi_src_flags.sv
module nmi_src_flags #(
  parameter int NUM = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] err_i,
  input  logic [NUM-1:0] keep_i,
  output logic [NUM-1:0] flag_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)              flag_o[i] <= 1'b0;
      else if (!keep_i[i])  flag_o[i] <= 1'b0;
      else if (err_i[i])    flag_o[i] <= 1'b1;
    end

    // R5: a disabled source ends up cleared
    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (rst)
      !$past(keep_i[i]) |-> !flag_o[i]);
    // R2/R3/R4: flag set by an enabled error and sticky afterwards
    assert_flag_set_R2: assert property (@(posedge clk) disable iff (rst)
      ($past(keep_i[i]) && $past(err_i[i])) |-> flag_o[i]);
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      ($past(keep_i[i]) && $past(flag_o[i])) |-> flag_o[i]);
  end
endmodule

// File: rtl/nmi_combine.sv
module nmi_combine
  import nmi_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] flag_i,
  input  nmi_cfg_t           cfg_i,
  output logic               nmi_o
);
  logic perr_term, serr_term, pci_term, chk_term, nmi_d;

  always_comb begin
    perr_term = flag_i[SRC_PERR] & cfg_i.perr_en & cfg_i.perr_to_serr;
    serr_term = flag_i[SRC_SERR] & cfg_i.serr_en;
    pci_term  = (perr_term | serr_term) & cfg_i.pci_err_en;
    chk_term  = flag_i[SRC_IOCHK] & cfg_i.chk_en;
    nmi_d     = (pci_term | chk_term) & ~cfg_i.mask;
  end

  always_ff @(posedge clk) begin
    if (rst) nmi_o <= 1'b0;
    else     nmi_o <= nmi_d;
  end

  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_i.mask) |-> !nmi_o);
  assert_parity_gate_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!(cfg_i.perr_en && cfg_i.perr_to_serr)) &&
     $past(flag_i[SRC_SERR] == 1'b0) && $past(flag_i[SRC_IOCHK] == 1'b0)) |-> !nmi_o);
  assert_serr_gate_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!cfg_i.serr_en) && $past(flag_i[SRC_PERR] == 1'b0) &&
     $past(flag_i[SRC_IOCHK] == 1'b0)) |-> !nmi_o);
  assert_nmi_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
    nmi_o |-> $past(|flag_i));
endmodule

// File: rtl/nmi_err_gate.sv
module nmi_err_gate
  import nmi_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               perr_n,
  input  logic               serr_n,
  input  logic               iochk_n,
  input  logic               cmd_perr_en,
  input  logic               cmd_serr_en,
  input  logic               fc_perr_to_serr,
  input  logic               pb_pci_err_en,
  input  logic               pb_chk_en,
  input  logic               nmi_mask,
  output logic               nmi_o,
  output logic [NUM_SRC-1:0] err_flags_o
);
  logic [NUM_SRC-1:0] err_async, err_sync, keep;
  nmi_cfg_t           cfg;

  assign err_async = ~{iochk_n, serr_n, perr_n};
  assign keep      = {pb_chk_en, pb_pci_err_en, pb_pci_err_en};

  always_comb begin
    cfg.perr_en      = cmd_perr_en;
    cfg.serr_en      = cmd_serr_en;
    cfg.perr_to_serr = fc_perr_to_serr;
    cfg.pci_err_en   = pb_pci_err_en;
    cfg.chk_en       = pb_chk_en;
    cfg.mask         = nmi_mask;
  end

  nmi_in_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(err_async), .sync_o(err_sync));

  nmi_src_flags #(.NUM(NUM_SRC)) u_flags (
    .clk(clk), .rst(rst), .err_i(err_sync), .keep_i(keep), .flag_o(err_flags_o));

  nmi_combine u_comb (
    .clk(clk), .rst(rst), .flag_i(err_flags_o), .cfg_i(cfg), .nmi_o(nmi_o));

  // R10: reset state
  assert_reset_clear_R10: assert property (@(posedge clk)
    $past(rst) |-> (!nmi_o && err_flags_o == '0));
endmodule

// File: tb/nmi_err_gate_bench.sv
module nmi_err_gate_bench;
  logic clk = 0, rst = 1;
  logic perr_n = 1, serr_n = 1, iochk_n = 1;
  logic cmd_perr_en = 0, cmd_serr_en = 0, fc_perr_to_serr = 0;
  logic pb_pci_err_en = 0, pb_chk_en = 0, nmi_mask = 0;
  logic nmi_o;
  logic [2:0] err_flags_o;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nmi_err_gate u_nmi_err_gate (.*);

  // reference model built from the requirements
  logic [2:0] m_s1, m_s2, m_fl;
  logic m_nmi;

  function automatic logic exp_nmi(input logic [2:0] fl);
    logic pci;
    pci = ((fl[0] & cmd_perr_en & fc_perr_to_serr) | (fl[1] & cmd_serr_en)) & pb_pci_err_en;
    return (pci | (fl[2] & pb_chk_en)) & ~nmi_mask;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_fl <= '0; m_nmi <= 0;
    end else begin
      m_s1 <= ~{iochk_n, serr_n, perr_n};
      m_s2 <= m_s1;
      m_fl[0] <= pb_pci_err_en & (m_fl[0] | m_s2[0]);
      m_fl[1] <= pb_pci_err_en & (m_fl[1] | m_s2[1]);
      m_fl[2] <= pb_chk_en & (m_fl[2] | m_s2[2]);
      m_nmi <= exp_nmi(m_fl);
    end
  end

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_up();
    end
  end

  initial begin
    cyc(3); rst = 0; cyc(1);
    chk({nmi_o, err_flags_o}, 4'b0000, "R10 reset");
    cmd_perr_en = 1; cmd_serr_en = 1; fc_perr_to_serr = 1;
    pb_pci_err_en = 1; pb_chk_en = 1;
    perr_n = 0; cyc(2);
    chk({3'b0, err_flags_o[0]}, 4'd0, "R1 not after 2 edges");
    cyc(1);
    chk({3'b0, err_flags_o[0]}, 4'd1, "R1 R2 flag after 3 edges");
    chk({3'b0, nmi_o}, 4'd0, "R9 nmi registered");
    cyc(1);
    chk({3'b0, nmi_o}, 4'd1, "R9 R6 nmi raised");
    perr_n = 1; cyc(6);
    chk({nmi_o, err_flags_o}, 4'b1001, "R2 sticky");
    fc_perr_to_serr = 0; cyc(1);
    chk({3'b0, nmi_o}, 4'd0, "R6 perr_to_serr off");
    fc_perr_to_serr = 1; cmd_perr_en = 0; cyc(1);
    chk({3'b0, nmi_o}, 4'd0, "R6 perr_en off");
    cmd_perr_en = 1; cyc(1);
    chk({3'b0, nmi_o}, 4'd1, "R6 restored");
    nmi_mask = 1; cyc(1);
    chk({nmi_o, err_flags_o}, 4'b0001, "R8 masked flag kept");
    nmi_mask = 0; cyc(1);
    chk({3'b0, nmi_o}, 4'd1, "R8 unmask");
    pb_pci_err_en = 0; cyc(1);
    chk({nmi_o, err_flags_o}, 4'b0000, "R5 clear pci flags");
    serr_n = 0; cyc(1); serr_n = 1; cyc(4);
    chk({nmi_o, err_flags_o}, 4'b0000, "R5 error ignored");
    pb_pci_err_en = 1; cmd_serr_en = 0;
    serr_n = 0; cyc(3);
    chk({nmi_o, err_flags_o}, 4'b0010, "R3 flag with serr_en off");
    serr_n = 1; cyc(3);
    chk({nmi_o, err_flags_o}, 4'b0010, "R7 blocked, R3 sticky");
    cmd_serr_en = 1; cyc(1);
    chk({3'b0, nmi_o}, 4'd1, "R7 serr_en on");
    pb_pci_err_en = 0; cyc(1); pb_pci_err_en = 1;
    iochk_n = 0; cyc(1); iochk_n = 1; cyc(3);
    chk({nmi_o, err_flags_o}, 4'b1100, "R4 iochk routed");
    pb_chk_en = 0; cyc(1);
    chk({nmi_o, err_flags_o}, 4'b0000, "R5 clear chk flag");
    pb_chk_en = 1; cyc(2);

    for (int i = 0; i < 3000; i++) begin
      perr_n  = ($urandom % 8) != 0;
      serr_n  = ($urandom % 8) != 0;
      iochk_n = ($urandom % 10) != 0;
      cmd_perr_en     = ($urandom % 4) != 0;
      cmd_serr_en     = ($urandom % 4) != 0;
      fc_perr_to_serr = ($urandom % 4) != 0;
      pb_pci_err_en   = ($urandom % 6) != 0;
      pb_chk_en       = ($urandom % 6) != 0;
      nmi_mask        = ($urandom % 4) == 0;
      cyc(1);
      chk({1'b0, err_flags_o}, {1'b0, m_fl}, "R2 R3 R4 R5 random flags");
      chk({3'b0, nmi_o}, {3'b0, m_nmi}, "R6 R7 R8 R9 random nmi");
    end
    done = 1;
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed1234));
  end
endmodule